// File: doc/BRIEF.md
# NAND Bus Width Adapter

The adapter sits between a host register port and a NAND-style flash bus. The device bus is 8 or 16 bits wide. Each host access is 1, 2 or 4 bytes and goes to one of three windows: command, address or data. The adapter turns the access into a short train of device beats. Beats go out in little-endian order. Each beat carries the latch strobe that belongs to the window. On reads, the data returned by the beats is packed into the host word.

A width mismatch is never treated as an error. A single byte sent to a 16-bit device goes out as one beat. The configuration inputs are sampled when a request is accepted:
- whether the chip select holds a NAND device;
- whether that device is 16 bits wide.

While a beat train is running, the request port is closed. A one-cycle completion pulse marks the end of every access, including accesses that are dropped.

Top module: `nand_bus_bridge`

## Requirements
- R1: The size code on `req_size` means 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. With an 8-bit device, an access of N bytes makes N beats. Byte k of `req_wdata` (bits 8k+7..8k) goes out in beat k on `dev_dout[7:0]`, and `dev_dout[15:8]` is zero.
- R2: With a 16-bit device, a 2-byte access makes one beat carrying `req_wdata[15:0]`. A 4-byte access makes two beats: `req_wdata[15:0]` first, then `req_wdata[31:16]`.
- R3: A 1-byte access to a 16-bit device makes exactly one beat. On a write, that beat carries the byte in `dev_dout[7:0]` and zero in `dev_dout[15:8]`. On a read, only `dev_din[7:0]` is kept, and every other bit of the host word is zero.
- R4: The window code on `req_win` means 0 = command, 1 = address, 2 or 3 = data. The command window holds `dev_cle` high and `dev_ale` low for the whole access. The address window holds `dev_ale` high and `dev_cle` low. The data window holds both low. The two latch strobes are never high together.
- R5: On a read, beat k is placed in ascending position of `rsp_rdata`: byte k on an 8-bit device, halfword k on a 16-bit device. Host bytes that no beat covers read as zero.
- R6: An access is dropped if either of these holds:
  - the NAND-device input is low;
  - the access is a read to the command or address window.
  A dropped access makes no beat, and `rsp_done` rises one cycle after acceptance with `rsp_rdata` zero.
- R7: Each beat lasts two cycles:
  - one cycle with its strobe low (`dev_we_n` for writes, `dev_re_n` for reads);
  - one cycle with the strobe high.
  Read data is sampled at the end of the low cycle. `rsp_done` is a one-cycle pulse in the cycle after the last release, 2N+1 cycles after acceptance for N beats.
- R8: `req_ready` is low from acceptance until the access completes. A request held on the port during that time causes no beat and does not change the access in progress.
- R9: After reset, `req_ready` is high, both strobes are high, both latch strobes and `dev_oe` are low, and `rsp_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_is_nand | input | 1 | Chip select holds a NAND-style device |
| cfg_wide | input | 1 | Device bus is 16 bits (0 = 8 bits) |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Adapter idle, request accepted this cycle if valid |
| req_win | input | 2 | Window: 0 command, 1 address, 2/3 data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 = 1 B, 1 = 2 B, 2/3 = 4 B |
| req_wdata | input | 32 | Host write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Packed read data, valid with `rsp_done` |
| dev_cle | output | 1 | Command latch enable |
| dev_ale | output | 1 | Address latch enable |
| dev_we_n | output | 1 | Write strobe, active low |
| dev_re_n | output | 1 | Read strobe, active low |
| dev_oe | output | 1 | Adapter drives the device data bus |
| dev_dout | output | 16 | Device write data |
| dev_din | input | 16 | Device read data |

## Verification
The embedded assertions check several rules on every cycle:
- the two latch strobes are never high together, and neither changes during a beat train;
- each strobe stays low for exactly one cycle;
- no strobe is active while the port reports ready;
- the beat index stays inside the beat count, and the latched access stays stable while busy;
- the high byte of a read is cleared when a single byte is read from a 16-bit device.

Only the directed scenarios can show the rest:
- the number of beats and their order for each width and size;
- the byte and halfword placement of both write and read data;
- the exact completion cycle;
- that dropped and overlapping requests leave the device bus untouched.

// File: rtl/nbb_pkg.sv
// Shared constants and types for the NAND bus width adapter.
// Assumes a host word that is a whole multiple of the wide device bus.
package nbb_pkg;
    localparam int HOST_W   = 32;
    localparam int NARROW_W = 8;
    localparam int WIDE_W   = 16;
    localparam int LANES    = HOST_W / NARROW_W;
    localparam int HALVES   = HOST_W / WIDE_W;
    localparam int PER_HALF = WIDE_W / NARROW_W;
    localparam int BEAT_IW  = $clog2(LANES);
    localparam int BEAT_CW  = $clog2(LANES + 1);
    localparam int HALF_IW  = (HALVES > 1) ? $clog2(HALVES) : 1;

    typedef enum logic [1:0] {
        WIN_CMD  = 2'd0,
        WIN_ADDR = 2'd1,
        WIN_DATA = 2'd2,
        WIN_DALT = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STRB = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef struct packed {
        logic               skip;
        logic               wr;
        logic               wide;
        logic               byte_only;
        logic               cle;
        logic               ale;
        logic [BEAT_CW-1:0] beats;
    } job_t;
endpackage

// File: rtl/nbb_decode.sv
// Access decoder: turns window, direction, size and chip-select setup
// into a job descriptor (beat count, latch strobes, drop flag).
// Purely combinational; the sequencer latches the result on acceptance.
module nbb_decode
    import nbb_pkg::*;
(
    input  logic [1:0] win,
    input  logic       write,
    input  logic [1:0] size,
    input  logic       is_nand,
    input  logic       wide,
    output job_t       job
);

    // Build the descriptor for the pending host request.
    always_comb begin
        job           = '0;
        job.wr        = write;
        job.wide      = wide;
        job.byte_only = (size == 2'd0);
        job.cle       = (win == WIN_CMD);
        job.ale       = (win == WIN_ADDR);
        job.skip      = !is_nand || (!write && (win == WIN_CMD || win == WIN_ADDR));
        case (size)
            2'd0:    job.beats = BEAT_CW'(1);
            2'd1:    job.beats = wide ? BEAT_CW'(1) : BEAT_CW'(PER_HALF);
            default: job.beats = wide ? BEAT_CW'(HALVES) : BEAT_CW'(LANES);
        endcase
    end

endmodule

// File: rtl/nbb_seq.sv
// Beat sequencer: holds the accepted job and steps through its beats,
// each beat being one strobe-low cycle followed by one release cycle.
// Raises a one-cycle done pulse in the cycle after the last release.
// Assumes start is only asserted while idle is high.
module nbb_seq
    import nbb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  job_t               job_in,
    output job_t               job,
    output phase_e             phase,
    output logic [BEAT_IW-1:0] beat,
    output logic               done,
    output logic               idle
);

    phase_e             phase_q;
    job_t               job_q;
    logic [BEAT_IW-1:0] beat_q;
    logic               done_q;
    logic               last_beat;

    // Final beat of the current train.
    assign last_beat = (BEAT_CW'(beat_q) + BEAT_CW'(1)) == job_q.beats;

    // Phase, beat and completion state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            job_q   <= '0;
            beat_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        job_q  <= job_in;
                        beat_q <= '0;
                        if (job_in.skip) begin
                            done_q <= 1'b1;
                        end else begin
                            phase_q <= PH_STRB;
                        end
                    end
                end
                PH_STRB: begin
                    phase_q <= PH_HOLD;
                end
                PH_HOLD: begin
                    if (last_beat) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        beat_q  <= beat_q + BEAT_IW'(1);
                        phase_q <= PH_STRB;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign job   = job_q;
    assign phase = phase_q;
    assign beat  = beat_q;
    assign done  = done_q;
    assign idle  = (phase_q == PH_IDLE);

    // R1: the beat index never runs past the beat count.
    p_beat_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |-> (BEAT_CW'(beat_q) < job_q.beats));

    // R8: the latched access stays put for the whole train.
    p_job_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(job_q));

    // R7: completion is only reported once back in idle.
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (phase_q == PH_IDLE));

endmodule

// File: rtl/nbb_lanes.sv
// Data lanes: selects the outgoing byte or halfword for the current
// beat and packs returning beats into ascending host byte lanes.
// Assumes capture is asserted only in the strobe-low cycle of a read.
module nbb_lanes
    import nbb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [HOST_W-1:0]  wdata_in,
    input  job_t               job,
    input  logic [BEAT_IW-1:0] beat,
    input  logic               capture,
    input  logic [WIDE_W-1:0]  din,
    output logic [WIDE_W-1:0]  dout,
    output logic [HOST_W-1:0]  rdata
);

    logic [HOST_W-1:0]   wdata_q;
    logic [NARROW_W-1:0] lane_q   [LANES];
    logic [NARROW_W-1:0] lane_val [LANES];
    logic [LANES-1:0]    lane_hit;
    logic [NARROW_W-1:0] wr_lane  [LANES];
    logic [WIDE_W-1:0]   wr_half  [HALVES];
    logic [HALF_IW-1:0]  half_idx;

    assign half_idx = HALF_IW'(beat);

    // Per-lane write slices, read targets and packed result.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int OFF = (l % PER_HALF) * NARROW_W;
        assign wr_lane[l] = wdata_q[l*NARROW_W +: NARROW_W];
        assign lane_hit[l] = job.wide ? (beat == BEAT_IW'(l / PER_HALF))
                                      : (beat == BEAT_IW'(l));
        if (OFF == 0) begin : g_low
            assign lane_val[l] = din[NARROW_W-1:0];
        end else begin : g_high
            assign lane_val[l] = job.wide ? (job.byte_only ? '0 : din[OFF +: NARROW_W])
                                          : din[NARROW_W-1:0];
        end
        assign rdata[l*NARROW_W +: NARROW_W] = lane_q[l];
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign wr_half[h] = wdata_q[h*WIDE_W +: WIDE_W];
    end

    // Latch write data on acceptance and collect read beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
            for (int l = 0; l < LANES; l++) lane_q[l] <= '0;
        end else if (start) begin
            wdata_q <= wdata_in;
            for (int l = 0; l < LANES; l++) lane_q[l] <= '0;
        end else if (capture) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_hit[l]) lane_q[l] <= lane_val[l];
            end
        end
    end

    // Outgoing beat data for the current beat.
    always_comb begin
        if (job.wide && !job.byte_only) begin
            dout = wr_half[half_idx];
        end else if (job.wide) begin
            dout = {{(WIDE_W-NARROW_W){1'b0}}, wdata_q[NARROW_W-1:0]};
        end else begin
            dout = {{(WIDE_W-NARROW_W){1'b0}}, wr_lane[beat]};
        end
    end

    // R3: a single byte read from a wide device leaves lane 1 clear.
    p_byte_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && job.wide && job.byte_only) |=> (lane_q[1] == '0));

endmodule

// File: rtl/nand_bus_bridge.sv
// NAND bus width adapter top: accepts one host access when idle,
// decodes it, runs its beat train on the device bus and returns
// packed read data with a completion pulse.
// Assumes the device bus timing is met by one-cycle strobes.
module nand_bus_bridge
    import nbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_is_nand,
    input  logic              cfg_wide,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_win,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [HOST_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [HOST_W-1:0] rsp_rdata,
    output logic              dev_cle,
    output logic              dev_ale,
    output logic              dev_we_n,
    output logic              dev_re_n,
    output logic              dev_oe,
    output logic [WIDE_W-1:0] dev_dout,
    input  logic [WIDE_W-1:0] dev_din
);

    job_t               job_new;
    job_t               job_cur;
    phase_e             phase;
    logic [BEAT_IW-1:0] beat;
    logic               idle;
    logic               start;
    logic               busy;
    logic               strobe_on;

    assign start     = req_valid && idle;
    assign busy      = !idle;
    assign strobe_on = (phase == PH_STRB);

    nbb_decode u_decode (
        .win     (req_win),
        .write   (req_write),
        .size    (req_size),
        .is_nand (cfg_is_nand),
        .wide    (cfg_wide),
        .job     (job_new)
    );

    nbb_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .job_in (job_new),
        .job    (job_cur),
        .phase  (phase),
        .beat   (beat),
        .done   (rsp_done),
        .idle   (idle)
    );

    nbb_lanes u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wdata_in (req_wdata),
        .job      (job_cur),
        .beat     (beat),
        .capture  (strobe_on && !job_cur.wr),
        .din      (dev_din),
        .dout     (dev_dout),
        .rdata    (rsp_rdata)
    );

    // Device-side strobes follow the phase and the latched job.
    assign req_ready = idle;
    assign dev_cle   = busy && job_cur.cle;
    assign dev_ale   = busy && job_cur.ale;
    assign dev_we_n  = !(strobe_on && job_cur.wr);
    assign dev_re_n  = !(strobe_on && !job_cur.wr);
    assign dev_oe    = busy && job_cur.wr;

    // R4: command and address latches are exclusive.
    p_latch_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_cle && dev_ale));

    // R4: latch strobes hold steady across a beat train.
    p_latch_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> ($stable(dev_cle) && $stable(dev_ale)));

    // R7: write strobe is low for a single cycle per beat.
    p_we_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_we_n |=> dev_we_n);

    // R7: read strobe is low for a single cycle per beat.
    p_re_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_re_n |=> dev_re_n);

    // R8: no strobe while the port is open for a new request.
    p_strobe_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_we_n || !dev_re_n) |-> !req_ready);

endmodule

// File: tb/test_nand_bus_bridge.sv
`timescale 1ns/1ps
module test_nand_bus_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_is_nand = 1'b1;
    logic        cfg_wide = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_win = 2'd2;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic        dev_cle, dev_ale, dev_we_n, dev_re_n, dev_oe;
    logic [15:0] dev_dout;
    logic [15:0] dev_din;

    int n_chk = 0;
    int n_err = 0;
    int wcnt  = 0;
    int rcnt  = 0;
    logic [15:0] wlog_d   [64];
    logic        wlog_cle [64];
    logic        wlog_ale [64];

    always #2.5 clk = ~clk;

    nand_bus_bridge i_nand_bus_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_is_nand(cfg_is_nand), .cfg_wide(cfg_wide),
        .req_valid(req_valid), .req_ready(req_ready), .req_win(req_win),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .dev_cle(dev_cle),
        .dev_ale(dev_ale), .dev_we_n(dev_we_n), .dev_re_n(dev_re_n),
        .dev_oe(dev_oe), .dev_dout(dev_dout), .dev_din(dev_din)
    );

    function automatic logic [15:0] pat(int i);
        return {8'h5A ^ i[7:0], 8'hC0 + i[7:0]};
    endfunction

    // Device model: read data follows the read-beat count.
    assign dev_din = pat(rcnt);

    always @(posedge clk) begin
        if (!dev_re_n) rcnt <= rcnt + 1;
        if (!dev_we_n && wcnt < 64) begin
            wlog_d[wcnt]   <= dev_dout;
            wlog_cle[wcnt] <= dev_cle;
            wlog_ale[wcnt] <= dev_ale;
            wcnt           <= wcnt + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] win, input logic wr, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        req_valid = 1'b1; req_win = win; req_write = wr; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        rd = rsp_rdata;
    endtask

    task automatic chk_beat(input string req, input int idx, input logic [15:0] d,
                            input logic cle, input logic ale);
        chk(req, $sformatf("beat %0d data", idx), {16'h0, wlog_d[idx]}, {16'h0, d});
        chk(req, $sformatf("beat %0d cle", idx), {31'h0, wlog_cle[idx]}, {31'h0, cle});
        chk(req, $sformatf("beat %0d ale", idx), {31'h0, wlog_ale[idx]}, {31'h0, ale});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9", "ready", {31'h0, req_ready}, 32'd1);
        chk("R9", "we_n/re_n", {30'h0, dev_we_n, dev_re_n}, 32'd3);
        chk("R9", "cle/ale/oe/done", {28'h0, dev_cle, dev_ale, dev_oe, rsp_done}, 32'd0);
    endtask

    task automatic t_narrow_writes();
        logic [31:0] rd; int cyc; int w0;
        cfg_wide = 1'b0;
        w0 = wcnt;
        run(2'd2, 1'b1, 2'd2, 32'h44332211, rd, cyc);
        chk("R7", "4B narrow write cycles", cyc, 9);
        chk("R1", "4B narrow beat count", wcnt - w0, 4);
        chk_beat("R1", w0,     16'h0011, 1'b0, 1'b0);
        chk_beat("R1", w0 + 1, 16'h0022, 1'b0, 1'b0);
        chk_beat("R1", w0 + 2, 16'h0033, 1'b0, 1'b0);
        chk_beat("R1", w0 + 3, 16'h0044, 1'b0, 1'b0);
        w0 = wcnt;
        run(2'd3, 1'b1, 2'd1, 32'h9999BEEF, rd, cyc);
        chk("R7", "2B narrow write cycles", cyc, 5);
        chk("R1", "2B narrow beat count", wcnt - w0, 2);
        chk_beat("R1", w0,     16'h00EF, 1'b0, 1'b0);
        chk_beat("R1", w0 + 1, 16'h00BE, 1'b0, 1'b0);
        w0 = wcnt;
        run(2'd2, 1'b1, 2'd0, 32'h1234565A, rd, cyc);
        chk("R7", "1B narrow write cycles", cyc, 3);
        chk("R1", "1B narrow beat count", wcnt - w0, 1);
        chk_beat("R1", w0, 16'h005A, 1'b0, 1'b0);
    endtask

    task automatic t_wide_writes();
        logic [31:0] rd; int cyc; int w0;
        cfg_wide = 1'b1;
        w0 = wcnt;
        run(2'd2, 1'b1, 2'd2, 32'hDDCCBBAA, rd, cyc);
        chk("R2", "4B wide write cycles", cyc, 5);
        chk("R2", "4B wide beat count", wcnt - w0, 2);
        chk_beat("R2", w0,     16'hBBAA, 1'b0, 1'b0);
        chk_beat("R2", w0 + 1, 16'hDDCC, 1'b0, 1'b0);
        w0 = wcnt;
        run(2'd2, 1'b1, 2'd1, 32'hFFFF1234, rd, cyc);
        chk("R2", "2B wide beat count", wcnt - w0, 1);
        chk_beat("R2", w0, 16'h1234, 1'b0, 1'b0);
    endtask

    task automatic t_wide_byte();
        logic [31:0] rd; int cyc; int w0; int r0;
        cfg_wide = 1'b1;
        w0 = wcnt;
        run(2'd2, 1'b1, 2'd0, 32'hFFFFFF77, rd, cyc);
        chk("R3", "1B wide write cycles", cyc, 3);
        chk("R3", "1B wide beat count", wcnt - w0, 1);
        chk_beat("R3", w0, 16'h0077, 1'b0, 1'b0);
        r0 = rcnt;
        run(2'd2, 1'b0, 2'd0, 32'h0, rd, cyc);
        chk("R3", "1B wide read beats", rcnt - r0, 1);
        chk("R3", "1B wide read data", rd, {24'h0, pat(r0)[7:0]});
    endtask

    task automatic t_windows();
        logic [31:0] rd; int cyc; int w0;
        cfg_wide = 1'b0;
        w0 = wcnt;
        run(2'd0, 1'b1, 2'd0, 32'h00000070, rd, cyc);
        chk("R4", "command beat count", wcnt - w0, 1);
        chk_beat("R4", w0, 16'h0070, 1'b1, 1'b0);
        w0 = wcnt;
        run(2'd1, 1'b1, 2'd1, 32'h00000302, rd, cyc);
        chk("R4", "address beat count", wcnt - w0, 2);
        chk_beat("R4", w0,     16'h0002, 1'b0, 1'b1);
        chk_beat("R4", w0 + 1, 16'h0003, 1'b0, 1'b1);
    endtask

    task automatic t_reads();
        logic [31:0] rd; int cyc; int r0;
        cfg_wide = 1'b0;
        r0 = rcnt;
        run(2'd2, 1'b0, 2'd2, 32'hFFFFFFFF, rd, cyc);
        chk("R7", "4B narrow read cycles", cyc, 9);
        chk("R5", "4B narrow read beats", rcnt - r0, 4);
        chk("R5", "4B narrow read data", rd,
            {pat(r0 + 3)[7:0], pat(r0 + 2)[7:0], pat(r0 + 1)[7:0], pat(r0)[7:0]});
        r0 = rcnt;
        run(2'd2, 1'b0, 2'd1, 32'h0, rd, cyc);
        chk("R5", "2B narrow read data", rd, {16'h0, pat(r0 + 1)[7:0], pat(r0)[7:0]});
        cfg_wide = 1'b1;
        r0 = rcnt;
        run(2'd3, 1'b0, 2'd2, 32'h0, rd, cyc);
        chk("R5", "4B wide read beats", rcnt - r0, 2);
        chk("R5", "4B wide read data", rd, {pat(r0 + 1), pat(r0)});
    endtask

    task automatic t_ignored();
        logic [31:0] rd; int cyc; int w0; int r0;
        cfg_wide = 1'b0;
        cfg_is_nand = 1'b0;
        w0 = wcnt;
        run(2'd0, 1'b1, 2'd0, 32'h000000FF, rd, cyc);
        chk("R6", "non-NAND write cycles", cyc, 1);
        chk("R6", "non-NAND write beats", wcnt - w0, 0);
        r0 = rcnt;
        run(2'd2, 1'b0, 2'd2, 32'h0, rd, cyc);
        chk("R6", "non-NAND read beats", rcnt - r0, 0);
        chk("R6", "non-NAND read data", rd, 32'h0);
        cfg_is_nand = 1'b1;
        r0 = rcnt;
        run(2'd1, 1'b0, 2'd2, 32'h0, rd, cyc);
        chk("R6", "address read cycles", cyc, 1);
        chk("R6", "address read beats", rcnt - r0, 0);
        chk("R6", "address read data", rd, 32'h0);
    endtask

    task automatic t_busy();
        int w0; int cyc;
        cfg_wide = 1'b0;
        w0 = wcnt;
        @(negedge clk);
        req_valid = 1'b1; req_win = 2'd2; req_write = 1'b1; req_size = 2'd2;
        req_wdata = 32'hA4A3A2A1;
        @(negedge clk);
        req_win = 2'd0; req_size = 2'd0; req_wdata = 32'h000000EE;
        chk("R8", "ready low while busy", {31'h0, req_ready}, 32'd0);
        cyc = 1;
        while (!rsp_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (cyc == 4) chk("R8", "ready low mid-train", {31'h0, req_ready}, 32'd0);
        end
        req_valid = 1'b0;
        chk("R8", "busy train cycles", cyc, 9);
        @(negedge clk);
        @(negedge clk);
        chk("R8", "beats from busy train", wcnt - w0, 4);
        chk_beat("R8", w0 + 3, 16'h00A4, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_narrow_writes();
        t_wide_writes();
        t_wide_byte();
        t_windows();
        t_reads();
        t_ignored();
        t_busy();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5 * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule